// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the feedback divider of a PLL synthesizer. It counts cycles of the high-rate input clock and emits one single-cycle pulse for every programmable number of input cycles. That pulse goes to a phase comparator. Inside, a prescaler divides the input by 32 or 33. A 5-bit swallow counter keeps the prescaler in its divide-by-33 mode for the first A prescaler periods of each output cycle. An 11-bit main counter ends the output cycle after B+1 prescaler periods. One output period therefore spans 33·A + 32·(B+1−A) = 32·B + A + 32 input clocks.

A 16-bit program word is written through a load strobe. It is captured at once, but the counters take it up only at the end of a division cycle, so no output period mixes two settings. A second strobe, issued together with the division pulse, marks the boundary at which a newly written word starts to govern. A flag reports a written word whose settings are outside the legal range.

Top module: `pls_divider`

## Requirements
- R1: For a program word with swallow count A (word bits 4..0) and main count B (word bits 15..5) satisfying A ≤ B, successive `div_o` pulses are exactly 32·B + A + 32 input clocks apart.
- R2: `div_o` is high for exactly one clock cycle per division cycle.
- R3: While `rst_n` is low, `div_o`, `applied_o` and `bad_o` are low. The reset word has A = 3 and B = 4, and the first `div_o` pulse follows the 163rd rising edge after reset is released.
- R4: A word loaded in the middle of a division cycle does not change the length of that cycle. It governs every cycle after the next `div_o` pulse.
- R5: A word loaded in the last input cycle of a division cycle, that is, sampled on the same edge that raises `div_o`, governs the very next division cycle.
- R6: `applied_o` is high together with the `div_o` pulse that ends a division cycle in which at least one load occurred, including its last cycle. It is low with every other `div_o` pulse and is never high without `div_o`.
- R7: `bad_o` is high from the edge after a load whose A exceeds B, or whose A exceeds 32, until the next load of a legal word. It is low after a load of a legal word.
- R8: With A = 0 the prescaler stays at divide-by-32 throughout, so pulses are 32·(B+1) input clocks apart. This covers the smallest ratio, 32, at A = B = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_load | input | 1 | Strobe: capture `prog_word` on this edge |
| prog_word | input | 16 | Program word: bits 4..0 swallow count A, bits 15..5 main count B |
| div_o | output | 1 | One-cycle pulse at the end of each division cycle |
| applied_o | output | 1 | One-cycle strobe with `div_o` when a new word takes effect |
| bad_o | output | 1 | High while the last loaded word is an illegal setting |

## Verification
Any wrong internal state shows up as a changed spacing of `div_o`. An off-by-one in the prescaler shifts one period by a single clock. A swallow counter that keeps its divide-by-33 mode too long, or drops it too early, adds or removes A-dependent clocks. A main counter with a wrong limit changes the spacing by multiples of 32. All of these appear within one division cycle of the fault. A reload applied at the wrong moment changes the length of the cycle in which the load occurred, or of the cycle that follows, and `applied_o` then pulses on the wrong boundary. Measuring every interval against the formula therefore catches such faults no later than the second pulse after a load.

// File: rtl/pls_div_pkg.sv
// Shared widths, program-word layout and legality rule for the
// pulse-swallow divider. Assumes the swallow field sits in the low bits.
package pls_div_pkg;

    localparam int unsigned PRE_LOG = 5;                  // prescaler base = 2**PRE_LOG
    localparam int unsigned SWAL_W  = 5;                  // swallow count width
    localparam int unsigned MAIN_W  = 11;                 // main count width
    localparam int unsigned WORD_W  = SWAL_W + MAIN_W;    // program word width

    typedef struct packed {
        logic [MAIN_W-1:0] main_cnt;   // bits 15..5
        logic [SWAL_W-1:0] swal_cnt;   // bits 4..0
    } prog_t;

    // Reset setting: A = 3, B = 4 -> 32*4 + 3 + 32 = 163 input clocks
    localparam prog_t RST_WORD = '{main_cnt: MAIN_W'(4), swal_cnt: SWAL_W'(3)};

    // Illegal when the swallow count exceeds the main count or the prescaler base
    function automatic logic setting_bad(input prog_t p);
        return (MAIN_W'(p.swal_cnt) > p.main_cnt) ||
               (int'(p.swal_cnt) > (1 << PRE_LOG));
    endfunction

endpackage

// File: rtl/pls_prescaler.sv
// Dual-modulus prescaler: one period lasts 2**PRE_LOG input clocks, or one
// more while mod_hi is high. Assumes mod_hi changes only right after pre_end.
module pls_prescaler #(
    parameter int unsigned PRE_LOG = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_hi,
    output logic pre_end
);
    localparam int unsigned CNT_W = PRE_LOG + 1;
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((1 << PRE_LOG) - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(1 << PRE_LOG);

    logic [CNT_W-1:0] cnt_q;

    // Flag the last input clock of the current prescaler period
    always_comb begin
        pre_end = (cnt_q == (mod_hi ? LAST_HI : LAST_LO));
    end

    // Count input clocks, wrapping at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pls_swallow.sv
// Swallow counter: holds the prescaler in its long modulus for the first
// reload_val prescaler periods of each division cycle. Assumes frame_end
// coincides with pre_end.
module pls_swallow #(
    parameter int unsigned SWAL_W  = 5,
    parameter logic [SWAL_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_end,
    input  logic              frame_end,
    input  logic [SWAL_W-1:0] reload_val,
    output logic              mod_hi
);
    logic [SWAL_W-1:0] left_q;

    // Long modulus while swallow periods remain
    always_comb begin
        mod_hi = (left_q != '0);
    end

    // Reload at a cycle boundary, otherwise count down per long period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= RST_VAL;
        end else if (frame_end) begin
            left_q <= reload_val;
        end else if (pre_end && (left_q != '0)) begin
            left_q <= left_q - SWAL_W'(1);
        end
    end
endmodule

// File: rtl/pls_main.sv
// Main counter: ends the division cycle after limit+1 prescaler periods.
// Assumes limit is steady within a division cycle.
module pls_main #(
    parameter int unsigned MAIN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_end,
    input  logic [MAIN_W-1:0] limit,
    output logic              frame_end
);
    logic [MAIN_W-1:0] per_q;

    // Last input clock of the last prescaler period
    always_comb begin
        frame_end = pre_end && (per_q == limit);
    end

    // Count completed prescaler periods within the division cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (frame_end) begin
            per_q <= '0;
        end else if (pre_end) begin
            per_q <= per_q + MAIN_W'(1);
        end
    end
endmodule

// File: rtl/pls_progreg.sv
// Program-word staging: captures loads at once and hands the newest word
// to the counters only on a division-cycle boundary. It also flags illegal
// words and marks boundaries at which a new word is taken up.
module pls_progreg
    import pls_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  prog_t word,
    input  logic  frame_end,
    output prog_t act_word,
    output prog_t next_word,
    output logic  bad_o,
    output logic  applied_o
);
    prog_t pend_q;
    prog_t act_q;
    logic  dirty_q;
    logic  bad_q;
    logic  applied_q;

    // Newest word, including one loaded on this very edge
    always_comb begin
        next_word = load ? word : pend_q;
    end

    // Staging register follows every load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= RST_WORD;
        end else begin
            pend_q <= next_word;
        end
    end

    // Active setting changes only at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= RST_WORD;
        end else if (frame_end) begin
            act_q <= next_word;
        end
    end

    // Remember a load seen since the last boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else if (frame_end) begin
            dirty_q <= 1'b0;
        end else if (load) begin
            dirty_q <= 1'b1;
        end
    end

    // Boundary strobe for a newly taken-up word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied_q <= 1'b0;
        end else begin
            applied_q <= frame_end && (dirty_q || load);
        end
    end

    // Legality flag of the most recently loaded word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= 1'b0;
        end else if (load) begin
            bad_q <= setting_bad(word);
        end
    end

    assign act_word  = act_q;
    assign bad_o     = bad_q;
    assign applied_o = applied_q;
endmodule

// File: rtl/pls_divider.sv
// Top of the pulse-swallow divider: prescaler, swallow and main counters
// plus program staging. Division ratio 32*B + A + 32 for legal words.
// Assumes a single clock domain and a synchronous active-low reset.
module pls_divider
    import pls_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_load,
    input  logic [WORD_W-1:0] prog_word,
    output logic              div_o,
    output logic              applied_o,
    output logic              bad_o
);
    logic  pre_end;
    logic  mod_hi;
    logic  frame_end;
    prog_t act_word;
    prog_t next_word;
    logic  div_q;

    pls_progreg u_progreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (prog_load),
        .word      (prog_t'(prog_word)),
        .frame_end (frame_end),
        .act_word  (act_word),
        .next_word (next_word),
        .bad_o     (bad_o),
        .applied_o (applied_o)
    );

    pls_prescaler #(.PRE_LOG(PRE_LOG)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_hi  (mod_hi),
        .pre_end (pre_end)
    );

    pls_swallow #(.SWAL_W(SWAL_W), .RST_VAL(RST_WORD.swal_cnt)) u_swallow (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_end    (pre_end),
        .frame_end  (frame_end),
        .reload_val (next_word.swal_cnt),
        .mod_hi     (mod_hi)
    );

    pls_main #(.MAIN_W(MAIN_W)) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_end   (pre_end),
        .limit     (act_word.main_cnt),
        .frame_end (frame_end)
    );

    // Register the division pulse for a glitch-free output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else begin
            div_q <= frame_end;
        end
    end

    assign div_o = div_q;
endmodule

// File: rtl/pls_divider_chk.sv
// Property checker for pls_divider, attached by bind. Watches the ports
// and the hand-offs between prescaler, swallow and main counters.
module pls_divider_chk
    import pls_div_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              prog_load,
    input logic [WORD_W-1:0] prog_word,
    input logic              div_o,
    input logic              applied_o,
    input logic              bad_o,
    input logic              pre_end,
    input logic              mod_hi,
    input logic              frame_end,
    input prog_t             act_word
);
    logic act_legal;
    prog_t w_now;

    always_comb begin
        act_legal = (MAIN_W'(act_word.swal_cnt) <= act_word.main_cnt);
        w_now     = prog_t'(prog_word);
    end

    // R2: the division pulse never lasts two cycles
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_o |=> !div_o);

    // R6: the boundary strobe appears only with a division pulse
    p_applied_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        applied_o |-> div_o);

    // R1: the modulus switches only at prescaler period boundaries
    p_modulus_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_end |=> $stable(mod_hi));

    // R1: with a legal setting every swallow period is used up by cycle end
    p_swallow_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && act_legal) |-> !mod_hi);

    // R7: flag follows the legality of the word just loaded
    p_bad_follows_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_load |=> (bad_o == ((MAIN_W'($past(w_now.swal_cnt)) > $past(w_now.main_cnt)) ||
                                 (int'($past(w_now.swal_cnt)) > (1 << PRE_LOG)))));

endmodule

bind pls_divider pls_divider_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_load (prog_load),
    .prog_word (prog_word),
    .div_o     (div_o),
    .applied_o (applied_o),
    .bad_o     (bad_o),
    .pre_end   (pre_end),
    .mod_hi    (mod_hi),
    .frame_end (frame_end),
    .act_word  (act_word)
);

// File: tb/pls_divider_bench.sv
module pls_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog_load;
    logic [15:0] prog_word;
    logic        div_o;
    logic        applied_o;
    logic        bad_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] cur;

    pls_divider u_pls_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_load (prog_load),
        .prog_word (prog_word),
        .div_o     (div_o),
        .applied_o (applied_o),
        .bad_o     (bad_o)
    );

    always #5 clk = ~clk;

    function automatic int ratio(input logic [15:0] w);
        return 32 * int'(w[15:5]) + int'(w[4:0]) + 32;
    endfunction

    function automatic bit is_bad(input logic [15:0] w);
        return (int'(w[4:0]) > int'(w[15:5])) || (int'(w[4:0]) > 32);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count negedges to the next pulse; optionally load w after negedge 'at'
    task automatic run_frame(input bit do_ld, input int at, input logic [15:0] w,
                             output int n, output bit app, output bit bad);
        n = 0; app = 1'b0; bad = 1'b0;
        while (1) begin
            @(negedge clk);
            prog_load = 1'b0;
            n++;
            if (div_o) begin
                app = applied_o;
                bad = bad_o;
                break;
            end
            if (n > 70000) break;
            if (do_ld && n == at) begin
                prog_word = w;
                prog_load = 1'b1;
            end
        end
    endtask

    // Load w mid-frame at position 'at', then check both affected frames
    task automatic apply(input logic [15:0] w, input int at, input string req);
        int n; bit app; bit bad;
        run_frame(1'b1, at, w, n, app, bad);
        chk(n == ratio(cur), "R4", "old ratio kept in load frame", n, ratio(cur));
        chk(app == 1'b1, "R6", "applied strobe at boundary", int'(app), 1);
        chk(bad == is_bad(w), "R7", "bad flag", int'(bad), int'(is_bad(w)));
        run_frame(1'b0, 0, 16'h0, n, app, bad);
        chk(n == ratio(w), req, "new ratio", n, ratio(w));
        chk(app == 1'b0, "R6", "no strobe without load", int'(app), 0);
        cur = w;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n; bit app; bit bad;
        logic [15:0] w;
        void'($urandom(32'd2024));
        rst_n = 1'b0; prog_load = 1'b0; prog_word = '0;
        repeat (4) @(negedge clk);
        chk(div_o == 1'b0, "R3", "div_o in reset", int'(div_o), 0);
        chk(applied_o == 1'b0, "R3", "applied_o in reset", int'(applied_o), 0);
        chk(bad_o == 1'b0, "R3", "bad_o in reset", int'(bad_o), 0);
        rst_n = 1'b1;
        cur = 16'h0083;
        run_frame(1'b0, 0, 16'h0, n, app, bad);
        chk(n == 163, "R3", "first pulse after reset", n, 163);
        chk(app == 1'b0, "R6", "no strobe on first pulse", int'(app), 0);
        run_frame(1'b0, 0, 16'h0, n, app, bad);
        chk(n == 163, "R1", "reset ratio repeats", n, 163);

        // Directed corner settings
        apply(16'h0000, 80, "R8");             // A=0 B=0 -> 32
        apply(16'h00A0, 1, "R8");              // A=0 B=5 -> 192
        apply(16'h03FF, 100, "R1");            // A=31 B=31 -> 1055
        apply(16'h0021, 500, "R1");            // A=1 B=1 -> 65

        // Load on the last cycle of a frame
        run_frame(1'b1, ratio(cur) - 1, 16'h0062, n, app, bad);
        chk(n == ratio(cur), "R5", "boundary-load frame length", n, ratio(cur));
        chk(app == 1'b1, "R5", "strobe on boundary load", int'(app), 1);
        cur = 16'h0062;
        run_frame(1'b0, 0, 16'h0, n, app, bad);
        chk(n == 130, "R5", "boundary load governs next frame", n, 130);

        // Random legal settings, loaded at random points
        for (int i = 0; i < 8; i++) begin
            int b; int a;
            b = int'($urandom_range(0, 60));
            a = int'($urandom_range(0, (b < 31) ? b : 31));
            w = {b[10:0], a[4:0]};
            apply(w, int'($urandom_range(1, ratio(cur) - 2)), "R1");
        end

        // Illegal word, then recovery
        run_frame(1'b1, ratio(cur) / 2, 16'h0047, n, app, bad);
        chk(n == ratio(cur), "R4", "frame before illegal word", n, ratio(cur));
        chk(bad == 1'b1, "R7", "bad flag on A>B", int'(bad), 1);
        run_frame(1'b1, 3, 16'h0083, n, app, bad);
        chk(bad == 1'b0, "R7", "bad cleared by legal load", int'(bad), 0);
        chk(app == 1'b1, "R6", "strobe after recovery load", int'(app), 1);
        cur = 16'h0083;
        run_frame(1'b0, 0, 16'h0, n, app, bad);
        chk(n == 163, "R1", "ratio after recovery", n, 163);

        // Largest legal setting
        apply(16'hFFFF, 40, "R1");             // A=31 B=2047 -> 65567
        @(negedge clk);
        chk(div_o == 1'b0, "R2", "pulse lasts one cycle", int'(div_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule